// File: doc/BRIEF.md
# Compare-Shortcut Timer/Counter

A register-mapped timer/counter with four compare/capture channels, meant to sit on a simple 32-bit peripheral bus. In timer mode, once started, it advances on a tick that a binary prescaler derives from the system clock, assumed to be 16 MHz. In counter mode it advances by one each time software triggers a count task. The counter width is chosen at run time (8, 16, 24 or 32 bits), and the count wraps within that width.

Each channel holds a compare value and a sticky compare event. The event sets when the counter steps onto the channel's value. Per-channel shortcut bits can zero the counter or halt the timer on that match. A capture task copies the live count into a channel's compare register. One level interrupt output is the OR of every event whose enable bit is set. The enable mask is changed through separate set and clear registers, and both of them read back the mask.

A two-state run machine holds the timer state. In HALTED the counter does not tick. The GO transition (a start task in timer mode) moves it to RUNNING. The HALT transition (a stop or shutdown task, or a stop-shortcut match) returns it to HALTED, and HALT wins if both requests arrive in the same cycle.

Bus map (byte addresses, 8-bit address). Tasks: start 0x00, stop 0x04, count 0x08, clear 0x0C, shutdown 0x10, capture i at 0x40+4i. Events: event i at 0x80+4i. Configuration: shortcuts 0xC0, enable-set 0xC4, enable-clear 0xC8, mode 0xCC (bit 0: 0 timer, 1 counter), width 0xD0, prescale 0xD4. Compare values: compare i at 0xE0+4i. Read data appears on `bus_rdata` one clock after the read request.

Top module: `cmpshort_timer`

## Requirements
- R1: The width field (bits 1:0) selects the counter width: 0 gives 16 bits, 1 gives 8, 2 gives 24 and 3 gives 32. The count wraps to zero modulo 2^width.
- R2: In timer mode a running counter advances once every 2^p clocks, where p is the prescale field. The first step comes 2^p clocks after the start edge. Prescale writes above 9 are stored and read back as 9.
- R3: Event i reads 1 from the clock after the counter steps onto compare i and stays 1 until a write of value 0 to its address. Nonzero writes to an event address are ignored.
- R4: With shortcut bit i set, a match on channel i loads zero into the counter instead of the matched value.
- R5: With shortcut bit i+8 set, a match on channel i moves the run machine to HALTED, and the counter keeps the matched value.
- R6: `irq` is high exactly when some event i is 1 and its enable bit 16+i is set. Writing ones to enable-set sets those bits, writing ones to enable-clear clears them, and both addresses read back the mask at bits 16+i.
- R7: The start task has effect only in timer mode, and the count task increments only in counter mode.
- R8: A stop task and a shutdown task each return the run machine to HALTED, freezing the count.
- R9: A clear task zeroes the counter and wins over a tick in the same cycle. It does not change the run state.
- R10: Capture task i loads compare i with the count held before that clock edge, so a tick in the same cycle is not included.
- R11: Compare values are truncated to the width in force when written and are re-masked to the current width when read and compared.
- R12: After reset, all configuration, compare values, events, the count and the run state are zero, and `irq` is low.
- R13: A task fires only when bit 0 of the written value is 1. Task writes of 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address of the request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after a read |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situations to reach from the ports are the exact-cycle coincidences: a clear task landing on a tick, a capture landing on a tick, and a stop shortcut freezing the count on the matching step. The bench reaches them by running the prescaler at zero, so that every clock is a tick, and by issuing bus writes on back-to-back cycles right after the start edge. The expected count is then the number of idle clocks it inserted. Event behaviour is swept in counter mode over every count length from 0 to 16 against four staggered compare values, with each expected event bit derived arithmetically.

// File: rtl/cst_pkg.sv
package cst_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    typedef enum logic {
        ST_HALTED  = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_t;

    typedef enum logic {
        MODE_TIMER   = 1'b0,
        MODE_COUNTER = 1'b1
    } cnt_mode_t;

    localparam logic [ADDR_W-1:0] A_START = 8'h00;
    localparam logic [ADDR_W-1:0] A_STOP  = 8'h04;
    localparam logic [ADDR_W-1:0] A_COUNT = 8'h08;
    localparam logic [ADDR_W-1:0] A_CLEAR = 8'h0C;
    localparam logic [ADDR_W-1:0] A_SHUT  = 8'h10;
    localparam logic [ADDR_W-1:0] A_CAP0  = 8'h40;
    localparam logic [ADDR_W-1:0] A_EVT0  = 8'h80;
    localparam logic [ADDR_W-1:0] A_SHORT = 8'hC0;
    localparam logic [ADDR_W-1:0] A_IESET = 8'hC4;
    localparam logic [ADDR_W-1:0] A_IECLR = 8'hC8;
    localparam logic [ADDR_W-1:0] A_MODE  = 8'hCC;
    localparam logic [ADDR_W-1:0] A_WIDTH = 8'hD0;
    localparam logic [ADDR_W-1:0] A_PRESC = 8'hD4;
    localparam logic [ADDR_W-1:0] A_CC0   = 8'hE0;

    localparam int STOP_SH_POS = 8;
    localparam int IE_POS      = 16;

    // Encoded width select: 0 -> 16, 1 -> 8, 2 -> 24, 3 -> 32 bits
    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] sel);
        logic [DATA_W-1:0] m;
        unique case (sel)
            2'd0: m = 32'h0000_FFFF;
            2'd1: m = 32'h0000_00FF;
            2'd2: m = 32'h00FF_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cst_prescaler.sv
module cst_prescaler #(
    parameter int PRESC_MAX = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [3:0] presc,
    output logic       tick
);
    localparam int DIV_W = (PRESC_MAX > 0) ? PRESC_MAX : 1;
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] low_mask;

    always_comb low_mask = (ONE << presc) - ONE;

    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (!run)   div_q <= '0;
        else             div_q <= div_q + ONE;
    end

    assign tick = run && ((div_q & low_mask) == low_mask);
endmodule

// File: rtl/cst_channel.sv
module cst_channel
    import cst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] cnt_now,
    input  logic [DATA_W-1:0] cnt_next,
    input  logic              advance,
    input  logic              cc_wr,
    input  logic [DATA_W-1:0] cc_wdata,
    input  logic              capture,
    input  logic              evt_clr,
    output logic [DATA_W-1:0] cc_val,
    output logic              evt,
    output logic              hit
);
    logic [DATA_W-1:0] cc_q;
    logic              evt_q;

    assign cc_val = cc_q & mask;
    assign hit    = advance && (cnt_next == cc_val);
    assign evt    = evt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       cc_q <= '0;
        else if (capture) cc_q <= cnt_now;
        else if (cc_wr)   cc_q <= cc_wdata & mask;
    end

    // a new match outranks a software clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)       evt_q <= 1'b0;
        else if (hit)     evt_q <= 1'b1;
        else if (evt_clr) evt_q <= 1'b0;
    end
endmodule

// File: rtl/cst_run_fsm.sv
module cst_run_fsm
    import cst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic halt_req,
    output logic running
);
    run_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED:  if (start_req && !halt_req) state_d = ST_RUNNING; // GO
            ST_RUNNING: if (halt_req)               state_d = ST_HALTED;  // HALT
            default:    state_d = ST_HALTED;
        endcase
    end

    always_comb begin
        running = (state_q == ST_RUNNING);
    end
endmodule

// File: rtl/cmpshort_timer.sv
module cmpshort_timer
    import cst_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int PRESC_MAX = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam logic [3:0] PMAX = 4'(PRESC_MAX);

    cnt_mode_t         mode_q;
    logic [1:0]        width_q;
    logic [3:0]        presc_q;
    logic [NUM_CH-1:0] sh_clr_q;
    logic [NUM_CH-1:0] sh_stop_q;
    logic [NUM_CH-1:0] ie_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] rdata_q;

    logic [DATA_W-1:0] cnt_mask, cnt_eff, cnt_inc;
    logic [NUM_CH-1:0] evt_vec, hit_vec;
    logic [DATA_W-1:0] cc_vals [NUM_CH];
    logic              running, tick, advance, clr_hit, stop_hit;
    logic              wr, trig;
    logic              t_start, t_stop, t_count, t_clear, t_shut;
    logic [DATA_W-1:0] rd_val;

    assign wr      = bus_valid && bus_write;
    assign trig    = wr && bus_wdata[0];
    assign t_start = trig && (bus_addr == A_START);
    assign t_stop  = trig && (bus_addr == A_STOP);
    assign t_count = trig && (bus_addr == A_COUNT);
    assign t_clear = trig && (bus_addr == A_CLEAR);
    assign t_shut  = trig && (bus_addr == A_SHUT);

    assign cnt_mask = width_mask(width_q);
    assign cnt_eff  = cnt_q & cnt_mask;
    assign cnt_inc  = (cnt_eff + DATA_W'(1)) & cnt_mask;

    cst_prescaler #(.PRESC_MAX(PRESC_MAX)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running && (mode_q == MODE_TIMER)),
        .presc (presc_q),
        .tick  (tick)
    );

    // clear task suppresses the step entirely
    assign advance = !t_clear &&
                     ((running && (mode_q == MODE_TIMER) && tick) ||
                      (t_count && (mode_q == MODE_COUNTER)));

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            localparam logic [ADDR_W-1:0] CAP_A = A_CAP0 + ADDR_W'(4 * g);
            localparam logic [ADDR_W-1:0] EVT_A = A_EVT0 + ADDR_W'(4 * g);
            localparam logic [ADDR_W-1:0] CC_A  = A_CC0  + ADDR_W'(4 * g);
            cst_channel u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .mask     (cnt_mask),
                .cnt_now  (cnt_eff),
                .cnt_next (cnt_inc),
                .advance  (advance),
                .cc_wr    (wr && (bus_addr == CC_A)),
                .cc_wdata (bus_wdata),
                .capture  (trig && (bus_addr == CAP_A)),
                .evt_clr  (wr && (bus_addr == EVT_A) && (bus_wdata == '0)),
                .cc_val   (cc_vals[g]),
                .evt      (evt_vec[g]),
                .hit      (hit_vec[g])
            );
        end
    endgenerate

    assign clr_hit  = |(hit_vec & sh_clr_q);
    assign stop_hit = |(hit_vec & sh_stop_q);

    cst_run_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (t_start && (mode_q == MODE_TIMER)),
        .halt_req  (t_stop || t_shut || stop_hit),
        .running   (running)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (t_clear || clr_hit) cnt_q <= '0;
        else if (advance)           cnt_q <= cnt_inc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_TIMER;
            width_q   <= '0;
            presc_q   <= '0;
            sh_clr_q  <= '0;
            sh_stop_q <= '0;
            ie_q      <= '0;
        end else if (wr) begin
            unique case (bus_addr)
                A_MODE:  mode_q  <= cnt_mode_t'(bus_wdata[0]);
                A_WIDTH: width_q <= bus_wdata[1:0];
                A_PRESC: presc_q <= (bus_wdata[3:0] > PMAX) ? PMAX : bus_wdata[3:0];
                A_SHORT: begin
                    sh_clr_q  <= bus_wdata[0 +: NUM_CH];
                    sh_stop_q <= bus_wdata[STOP_SH_POS +: NUM_CH];
                end
                A_IESET: ie_q <= ie_q | bus_wdata[IE_POS +: NUM_CH];
                A_IECLR: ie_q <= ie_q & ~bus_wdata[IE_POS +: NUM_CH];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (bus_addr)
            A_MODE:  rd_val[0] = mode_q;
            A_WIDTH: rd_val[1:0] = width_q;
            A_PRESC: rd_val[3:0] = presc_q;
            A_SHORT: begin
                rd_val[0 +: NUM_CH]           = sh_clr_q;
                rd_val[STOP_SH_POS +: NUM_CH] = sh_stop_q;
            end
            A_IESET, A_IECLR: rd_val[IE_POS +: NUM_CH] = ie_q;
            default: ;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == A_EVT0 + ADDR_W'(4 * i)) rd_val = DATA_W'(evt_vec[i]);
            if (bus_addr == A_CC0 + ADDR_W'(4 * i))  rd_val = cc_vals[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                       rdata_q <= '0;
        else if (bus_valid && !bus_write) rdata_q <= rd_val;
    end

    assign bus_rdata = rdata_q;
    assign irq       = |(evt_vec & ie_q);
endmodule

// File: rtl/cst_checker.sv
module cst_checker
    import cst_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic              running,
    input logic              mode,
    input logic [DATA_W-1:0] cnt_q,
    input logic [NUM_CH-1:0] evt_vec,
    input logic [NUM_CH-1:0] hit_vec,
    input logic [NUM_CH-1:0] ie_q,
    input logic [NUM_CH-1:0] sh_clr_q,
    input logic [NUM_CH-1:0] sh_stop_q
);
    logic trig;
    assign trig = bus_valid && bus_write && bus_wdata[0];

    assert_halt_task_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && ((bus_addr == A_STOP) || (bus_addr == A_SHUT))) |=> !running);

    assert_clear_task_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && (bus_addr == A_CLEAR)) |=> (cnt_q == '0));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && (bus_addr == A_START) && mode && !running) |=> !running);

    assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q == '0) |-> !irq);

    assert_stop_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit_vec & sh_stop_q)) |=> !running);

    assert_clr_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit_vec & sh_clr_q)) |=> (cnt_q == '0));

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_stk
            assert_event_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (evt_vec[g] && !(bus_valid && bus_write &&
                                 (bus_addr == A_EVT0 + ADDR_W'(4 * g)) &&
                                 (bus_wdata == '0)))
                |=> evt_vec[g]);
        end
    endgenerate
endmodule

bind cmpshort_timer cst_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .running   (running),
    .mode      (mode_q),
    .cnt_q     (cnt_q),
    .evt_vec   (evt_vec),
    .hit_vec   (hit_vec),
    .ie_q      (ie_q),
    .sh_clr_q  (sh_clr_q),
    .sh_stop_q (sh_stop_q)
);

// File: tb/cmpshort_timer_test.sv
module cmpshort_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    cmpshort_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam logic [7:0] START = 8'h00, STOP = 8'h04, COUNT = 8'h08, CLEAR = 8'h0C,
        SHUT = 8'h10, CAP0 = 8'h40, EVT0 = 8'h80, SHORT = 8'hC0, IESET = 8'hC4,
        IECLR = 8'hC8, MODE = 8'hCC, WIDTH = 8'hD0, PRESC = 8'hD4, CC0 = 8'hE0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] wmask(input int w);
        int bits;
        bits = (w == 0) ? 16 : (w == 1) ? 8 : (w == 2) ? 24 : 32;
        return 32'((64'd1 << bits) - 64'd1);
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R12: reset values
        rd(MODE, v);  chk("R12 mode", v, 0);
        rd(WIDTH, v); chk("R12 width", v, 0);
        rd(PRESC, v); chk("R12 presc", v, 0);
        rd(SHORT, v); chk("R12 shorts", v, 0);
        rd(IESET, v); chk("R12 ie", v, 0);
        rd(EVT0, v);  chk("R12 evt0", v, 0);
        rd(CC0 + 8'd12, v); chk("R12 cc3", v, 0);
        chk("R12 irq", {31'b0, irq}, 0);

        // timer mode, 32-bit width
        wr(WIDTH, 3);
        // R2 + R10: prescaler sweep, D idle clocks between start and capture
        for (int p = 0; p < 4; p++) begin
            wr(PRESC, p);
            wr(CLEAR, 1);
            wr(START, 1);
            idle(13);
            wr(CAP0, 1);
            wr(STOP, 1);
            rd(CC0, v);
            chk($sformatf("R2 presc=%0d", p), v, 32'(13 >> p));
        end
        wr(PRESC, 15);
        rd(PRESC, v); chk("R2 clamp", v, 9);
        wr(PRESC, 0);

        // R10: capture in the first tick cycle samples pre-increment count
        wr(CLEAR, 1); wr(START, 1); wr(CAP0, 1); wr(STOP, 1);
        rd(CC0, v); chk("R10 capture on tick", v, 0);

        // R9: clear coinciding with a tick wins
        wr(CLEAR, 1); wr(START, 1); idle(5);
        wr(CLEAR, 1); wr(CAP0, 1); wr(STOP, 1);
        rd(CC0, v); chk("R9 clear wins", v, 0);

        // R8: shutdown and stop freeze the count
        wr(CLEAR, 1); wr(START, 1); idle(4); wr(SHUT, 1); idle(10);
        wr(CAP0, 1); rd(CC0, v); chk("R8 shutdown", v, 5);
        wr(CLEAR, 1); wr(START, 1); idle(4); wr(STOP, 1); idle(10);
        wr(CAP0, 1); rd(CC0, v); chk("R8 stop", v, 5);

        // R13: task write of 0 ignored
        wr(CLEAR, 1); wr(START, 0); idle(5);
        wr(CAP0, 1); rd(CC0, v); chk("R13 zero start", v, 0);

        // R7: count task ignored in timer mode
        wr(COUNT, 1); wr(COUNT, 1); wr(COUNT, 1);
        wr(CAP0, 1); rd(CC0, v); chk("R7 count in timer", v, 0);

        // R5: stop shortcut on channel 2
        wr(CLEAR, 1); wr(CC0 + 8'd8, 7); wr(SHORT, 32'h400); wr(EVT0 + 8'd8, 0);
        wr(START, 1); idle(20);
        wr(CAP0 + 8'd12, 1); rd(CC0 + 8'd12, v); chk("R5 stop hold", v, 7);
        rd(EVT0 + 8'd8, v); chk("R5 event", v, 1);
        wr(SHORT, 0);

        // counter mode, 8-bit
        wr(MODE, 1); wr(WIDTH, 1); wr(CLEAR, 1);
        // R7: start ignored in counter mode
        wr(START, 1); idle(10);
        wr(CAP0, 1); rd(CC0, v); chk("R7 start in counter", v, 0);

        // R3: event sweep with staggered compare values
        for (int i = 0; i < 4; i++) wr(CC0 + 8'(4 * i), 32'(4 * i + 2));
        for (int n = 0; n <= 16; n++) begin
            wr(CLEAR, 1);
            for (int i = 0; i < 4; i++) wr(EVT0 + 8'(4 * i), 0);
            for (int k = 0; k < n; k++) wr(COUNT, 1);
            for (int i = 0; i < 4; i++) begin
                rd(EVT0 + 8'(4 * i), v);
                chk($sformatf("R3 n=%0d ch=%0d", n, i), v, {31'b0, (4 * i + 2) <= n});
            end
        end

        // R1: 8-bit wrap
        wr(CLEAR, 1);
        for (int k = 0; k < 259; k++) wr(COUNT, 1);
        wr(CAP0 + 8'd4, 1); rd(CC0 + 8'd4, v); chk("R1 wrap 8", v, 3);

        // R4: clear shortcut on channel 0
        wr(CLEAR, 1); wr(CC0, 5); wr(SHORT, 1); wr(EVT0, 0);
        for (int k = 0; k < 7; k++) wr(COUNT, 1);
        wr(CAP0 + 8'd4, 1); rd(CC0 + 8'd4, v); chk("R4 clear short", v, 2);
        rd(EVT0, v); chk("R4 event", v, 1);
        wr(SHORT, 0);

        // R3: nonzero write ignored
        wr(EVT0, 5); rd(EVT0, v); chk("R3 nonzero ignored", v, 1);

        // R6: interrupt enables (event 0 and event 2 are set)
        chk("R6 irq masked", {31'b0, irq}, 0);
        wr(IESET, 32'h1_0000);
        chk("R6 irq on", {31'b0, irq}, 1);
        wr(IESET, 32'h4_0000);
        rd(IESET, v); chk("R6 set readback", v, 32'h5_0000);
        rd(IECLR, v); chk("R6 clr readback", v, 32'h5_0000);
        wr(IECLR, 32'h1_0000);
        chk("R6 irq via ch2", {31'b0, irq}, 1);
        wr(EVT0 + 8'd8, 0);
        chk("R6 irq off", {31'b0, irq}, 0);
        wr(EVT0, 0); rd(EVT0, v); chk("R3 cleared", v, 0);
        wr(IECLR, 32'hF_0000);

        // R11: truncation per width and re-mask on read
        for (int w = 0; w < 4; w++) begin
            wr(WIDTH, w);
            rd(WIDTH, v); chk($sformatf("R1 width=%0d", w), v, 32'(w));
            wr(CC0 + 8'd12, 32'h1234_5678);
            rd(CC0 + 8'd12, v);
            chk($sformatf("R11 width=%0d", w), v, 32'h1234_5678 & wmask(w));
        end
        wr(WIDTH, 3); wr(CC0 + 8'd12, 32'hCAFE_BABE);
        wr(WIDTH, 1); rd(CC0 + 8'd12, v); chk("R11 remask", v, 32'hBE);
        wr(WIDTH, 3); rd(CC0 + 8'd12, v); chk("R11 widen", v, 32'hCAFE_BABE);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule